// File: doc/BRIEF.md
# Transmit-Ready Command Handler

A host processor writes a 32-bit transmit-ready command to announce that a new packet descriptor has been appended to the send queue of a virtual channel. The block decodes the command and latches the descriptor address. It checks the channel number and the channel's transmit mode against a per-channel table. When those checks pass, it asks the descriptor fetch logic to obtain the per-packet information. When everything succeeds, it emits a one-cycle activation for that channel's scheduling-table entry. In every case it posts a 32-bit indication word that repeats the command and carries an error flag.

Each channel is bound to the transmit mode of its first successful command, either native cell mode or IP-over-ATM mode. A later command that asks for the other mode on that channel is refused and is not scheduled. IP-over-ATM commands do not name a channel: their channel field must be zero, and they use one fixed table entry selected by a parameter.

Top module: `txrdy_cmd_unit`

## Requirements
- R1: A write whose bits 31:28 are not 4'b0110 is ignored. Busy stays low, and the indication valid flag and indication word keep their values.
- R2: Busy rises in the cycle after an accepted write and stays high until the cycle in which the indication becomes valid, when it drops. Writes made while busy is high are ignored.
- R3: A native-mode command (bit 24 = 1) with channel number (bits 17:6) below NUM_CH, a free or native-bound channel and a successful fetch produces an indication with bit 23 = 0. It also produces exactly one sched_set_o pulse, carrying that channel number and coinciding with the first cycle of the new indication.
- R4: A native-mode command with a channel number of NUM_CH or more sets bit 23 of the indication. No fetch is requested and no activation is issued.
- R5: An IP-over-ATM command (bit 24 = 0) with a zero channel field is handled on channel IPOA_CH. An IP-over-ATM command with a non-zero channel field is flagged as an error, with no fetch and no activation.
- R6: A fetch that ends with fetch_fail_i high sets bit 23 and issues no activation. The channel stays unbound.
- R7: A command that asks for the other mode on a channel already bound by an earlier successful command sets bit 23. No fetch is requested and no activation is issued.
- R8: The indication word holds 4'b0110 in bits 31:28, the command's mode in bit 24, the error flag in bit 23 and the command's channel field in bits 17:6. All other bits are zero, whatever the host wrote there, including bit 23.
- R9: fetch_addr_o equals desc_addr_i as sampled with the accepted write. It stays stable while fetch_req_o is held, and fetch_req_o stays high until fetch_done_i.
- R10: After reset, busy, indication valid, indication word, fetch request and activation are all zero, and every channel is unbound.
- R11: The indication valid flag and word stay unchanged from the moment they are posted until the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 32 | Command word |
| desc_addr_i | input | ADDR_W | Packet descriptor address, sampled with the write |
| fetch_req_o | output | 1 | Request to obtain the per-packet information |
| fetch_addr_o | output | ADDR_W | Descriptor address for the fetch |
| fetch_done_i | input | 1 | Fetch finished |
| fetch_fail_i | input | 1 | Fetch result was unusable (valid with done) |
| busy_o | output | 1 | Command in progress |
| ind_valid_o | output | 1 | Indication word is valid |
| ind_rdata_o | output | 32 | Indication word |
| sched_set_o | output | 1 | One-cycle scheduling-table activation |
| sched_ch_o | output | CH_W | Channel being activated |

## Verification
The hardest situation to reach is a mode conflict. It only appears when one channel has already been bound by an earlier command that fully succeeded, and the IP-over-ATM channel also shares an entry with native channel IPOA_CH. The directed prefix binds that shared entry in IP-over-ATM mode and then targets it in native mode. The random phase uses channel numbers drawn from a narrow range so that bound channels are hit repeatedly in both modes, with occasional fetch failures and out-of-range numbers. A write injected during a long fetch wait covers the busy-ignore case.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam logic [3:0] TXR_OPCODE = 4'b0110;
  localparam int OPC_LSB  = 28;
  localparam int MODE_BIT = 24;
  localparam int ERR_BIT  = 23;
  localparam int VC_LSB   = 6;
  localparam int VC_W     = 12;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_CHECK      = 2'd1,
    ST_WAIT_FETCH = 2'd2,
    ST_RESPOND    = 2'd3
  } txr_state_e;

  function automatic logic [31:0] build_ind(input logic mode, input logic err,
                                            input logic [VC_W-1:0] vc);
    return {TXR_OPCODE, 3'b000, mode, err, 5'b00000, vc, 6'b000000};
  endfunction
endpackage

// File: rtl/txr_decode.sv
module txr_decode
  import txr_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int IPOA_CH = 0,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [31:0]     cmd,
  output logic            is_cmd,
  output logic            mode,
  output logic [VC_W-1:0] vc,
  output logic            vc_ok,
  output logic [CH_W-1:0] ch
);
  logic unused_bits;
  assign unused_bits = ^{cmd[27:25], cmd[ERR_BIT:18], cmd[VC_LSB-1:0]};

  always_comb begin
    is_cmd = (cmd[31:OPC_LSB] == TXR_OPCODE);
    mode   = cmd[MODE_BIT];
    vc     = cmd[VC_LSB +: VC_W];
    if (mode) begin
      vc_ok = (32'(vc) < NUM_CH);
      ch    = vc[CH_W-1:0];
    end else begin
      vc_ok = (vc == '0);
      ch    = CH_W'(IPOA_CH);
    end
  end
endmodule

// File: rtl/txr_chan_table.sv
module txr_chan_table #(
  parameter int NUM_CH = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] look_ch,
  input  logic            look_mode,
  output logic            conflict,
  input  logic            bind_en,
  input  logic [CH_W-1:0] bind_ch,
  input  logic            bind_mode
);
  logic [NUM_CH-1:0] used_q;
  logic [NUM_CH-1:0] mode_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ent
    logic hit;
    assign hit = bind_en && (bind_ch == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        used_q[g] <= 1'b0;
        mode_q[g] <= 1'b0;
      end else if (hit) begin
        used_q[g] <= 1'b1;
        mode_q[g] <= bind_mode;
      end
    end
  end

  always_comb begin
    conflict = used_q[look_ch] && (mode_q[look_ch] != look_mode);
  end

  // R7: a channel is never rebound to the other mode
  p_bind_compat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bind_en |-> !(used_q[bind_ch] && (mode_q[bind_ch] != bind_mode)));
endmodule

// File: rtl/txr_ctrl_fsm.sv
module txr_ctrl_fsm
  import txr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_we,
  input  logic is_cmd,
  input  logic vc_ok,
  input  logic conflict,
  input  logic fetch_done,
  input  logic fetch_fail,
  output logic accept,
  output logic busy,
  output logic fetch_req,
  output logic respond,
  output logic err
);
  txr_state_e state_q, state_d;
  logic       err_q, err_d;

  always_comb begin
    accept  = cmd_we && is_cmd && (state_q == ST_IDLE);
    state_d = state_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_CHECK;
        err_d   = 1'b0;
      end
      ST_CHECK: begin
        if (!vc_ok || conflict) begin
          state_d = ST_RESPOND;
          err_d   = 1'b1;
        end else begin
          state_d = ST_WAIT_FETCH;
        end
      end
      ST_WAIT_FETCH: if (fetch_done) begin
        state_d = ST_RESPOND;
        err_d   = fetch_fail;
      end
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign fetch_req = (state_q == ST_WAIT_FETCH);
  assign respond   = (state_q == ST_RESPOND);
  assign err       = err_q;

  // R4: a bad channel number never reaches the fetch stage
  p_no_fetch_badvc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK) && !vc_ok |=> !fetch_req && err);
  // R7: a mode conflict goes straight to the response with the error set
  p_conflict_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK) && conflict |=> respond && err);
  // R9: the fetch request holds until done
  p_fetch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_done |=> fetch_req);
  // R2: busy is held up to the response cycle
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !respond |=> busy);
endmodule

// File: rtl/txrdy_cmd_unit.sv
module txrdy_cmd_unit
  import txr_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int IPOA_CH = 0,
  parameter int ADDR_W  = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we_i,
  input  logic [31:0]       cmd_wdata_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_done_i,
  input  logic              fetch_fail_i,
  output logic              busy_o,
  output logic              ind_valid_o,
  output logic [31:0]       ind_rdata_o,
  output logic              sched_set_o,
  output logic [CH_W-1:0]   sched_ch_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic            dec_is_cmd, dec_mode, dec_vc_ok;
  logic [VC_W-1:0] dec_vc;
  logic [CH_W-1:0] dec_ch;

  txr_decode #(.NUM_CH(NUM_CH), .IPOA_CH(IPOA_CH)) u_dec (
    .cmd    (cmd_wdata_i),
    .is_cmd (dec_is_cmd),
    .mode   (dec_mode),
    .vc     (dec_vc),
    .vc_ok  (dec_vc_ok),
    .ch     (dec_ch)
  );

  logic accept, respond, err, conflict;

  // latched command
  logic              mode_q, vc_ok_q;
  logic [VC_W-1:0]   vc_q;
  logic [CH_W-1:0]   ch_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      mode_q  <= 1'b0;
      vc_ok_q <= 1'b0;
      vc_q    <= '0;
      ch_q    <= '0;
      addr_q  <= '0;
    end else if (accept) begin
      mode_q  <= dec_mode;
      vc_ok_q <= dec_vc_ok;
      vc_q    <= dec_vc;
      ch_q    <= dec_ch;
      addr_q  <= desc_addr_i;
    end
  end

  txr_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_ns),
    .cmd_we     (cmd_we_i),
    .is_cmd     (dec_is_cmd),
    .vc_ok      (vc_ok_q),
    .conflict   (conflict),
    .fetch_done (fetch_done_i),
    .fetch_fail (fetch_fail_i),
    .accept     (accept),
    .busy       (busy_o),
    .fetch_req  (fetch_req_o),
    .respond    (respond),
    .err        (err)
  );

  logic bind_en;
  assign bind_en = respond && !err;

  txr_chan_table #(.NUM_CH(NUM_CH)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_ns),
    .look_ch   (ch_q),
    .look_mode (mode_q),
    .conflict  (conflict),
    .bind_en   (bind_en),
    .bind_ch   (ch_q),
    .bind_mode (mode_q)
  );

  // indication and activation registers
  logic            ind_valid_d, sched_d;
  logic [31:0]     ind_d;
  logic [CH_W-1:0] sched_ch_d;

  always_comb begin
    ind_valid_d = ind_valid_o;
    ind_d       = ind_rdata_o;
    sched_d     = 1'b0;
    sched_ch_d  = sched_ch_o;
    if (accept) begin
      ind_valid_d = 1'b0;
    end else if (respond) begin
      ind_valid_d = 1'b1;
      ind_d       = build_ind(mode_q, err, vc_q);
      sched_d     = !err;
      sched_ch_d  = ch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ind_valid_o <= 1'b0;
      ind_rdata_o <= '0;
      sched_set_o <= 1'b0;
      sched_ch_o  <= '0;
    end else begin
      ind_valid_o <= ind_valid_d;
      ind_rdata_o <= ind_d;
      sched_set_o <= sched_d;
      sched_ch_o  <= sched_ch_d;
    end
  end

  assign fetch_addr_o = addr_q;

  // R3: activation only with a clean, freshly posted indication
  p_sched_clean_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    sched_set_o |-> ind_valid_o && !ind_rdata_o[ERR_BIT]);
  // R3: activation is a single-cycle pulse
  p_sched_pulse_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    sched_set_o |=> !sched_set_o);
  // R9: fetch address steady during the request
  p_fetch_addr_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    fetch_req_o && $past(fetch_req_o) |-> $stable(fetch_addr_o));
  // R2: a valid indication means the handler is idle
  p_ind_idle_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    ind_valid_o |-> !busy_o);
  // R11: a posted indication holds while no command is accepted
  p_ind_hold_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    ind_valid_o && !accept |=> ind_valid_o && $stable(ind_rdata_o));
endmodule

// File: tb/sim_txrdy_cmd_unit.sv
module sim_txrdy_cmd_unit;
  localparam int NUM_CH  = 16;
  localparam int IPOA_CH = 0;
  localparam int ADDR_W  = 32;
  localparam int CH_W    = $clog2(NUM_CH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_we_i = 1'b0;
  logic [31:0]       cmd_wdata_i = '0;
  logic [ADDR_W-1:0] desc_addr_i = '0;
  logic              fetch_req_o;
  logic [ADDR_W-1:0] fetch_addr_o;
  logic              fetch_done_i = 1'b0;
  logic              fetch_fail_i = 1'b0;
  logic              busy_o, ind_valid_o, sched_set_o;
  logic [31:0]       ind_rdata_o;
  logic [CH_W-1:0]   sched_ch_o;

  txrdy_cmd_unit #(.NUM_CH(NUM_CH), .IPOA_CH(IPOA_CH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we_i), .cmd_wdata_i(cmd_wdata_i),
    .desc_addr_i(desc_addr_i), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fetch_done_i(fetch_done_i), .fetch_fail_i(fetch_fail_i), .busy_o(busy_o),
    .ind_valid_o(ind_valid_o), .ind_rdata_o(ind_rdata_o), .sched_set_o(sched_set_o),
    .sched_ch_o(sched_ch_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;
  bit m_used [NUM_CH];
  bit m_mode [NUM_CH];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input bit mode, input int vc, input bit junk);
    logic [31:0] w;
    w = {4'b0110, 3'b000, mode, 1'b0, 5'b00000, 12'(vc), 6'b000000};
    if (junk) w = w | 32'h0E7C_003F;
    return w;
  endfunction

  function automatic logic [31:0] exp_ind(input bit mode, input logic [11:0] vc, input bit e);
    return {4'b0110, 3'b000, mode, e, 5'b00000, vc, 6'b000000};
  endfunction

  // full transaction with checks; intrude injects a write while busy
  task automatic run_cmd(input logic [31:0] w, input logic [31:0] addr, input bit fail,
                         input int dly, input bit intrude);
    bit mode, vc_ok, confl, want_fetch, e, responded, seen;
    logic [11:0] vc;
    int ch, cnt, sched_n, fetch_n, sched_seen;
    string tag;
    mode = w[24];
    vc = w[17:6];
    vc_ok = mode ? (int'(vc) < NUM_CH) : (vc == 0);
    ch = mode ? int'(vc) % NUM_CH : IPOA_CH;
    confl = vc_ok && m_used[ch] && (m_mode[ch] != mode);
    want_fetch = vc_ok && !confl;
    e = !want_fetch || fail;
    if (!vc_ok) tag = mode ? "R4" : "R5";
    else if (confl) tag = "R7";
    else if (fail) tag = "R6";
    else tag = "R3";

    cmd_we_i = 1'b1; cmd_wdata_i = w; desc_addr_i = addr;
    @(negedge clk);
    cmd_we_i = 1'b0; desc_addr_i = ~addr;
    chk(busy_o == 1'b1, "R2 busy after write", 32'(busy_o), 32'd1);
    responded = 0; seen = 0; cnt = 0; sched_n = 0; fetch_n = 0; sched_seen = -1;
    for (int i = 0; i < 80; i++) begin
      fetch_done_i = 1'b0; fetch_fail_i = 1'b0; cmd_we_i = 1'b0;
      if (fetch_req_o && !responded) begin
        if (!seen) begin
          seen = 1; fetch_n++;
          chk(fetch_addr_o == addr, "R9 fetch address", fetch_addr_o, addr);
        end
        if (intrude && cnt == 1) begin
          cmd_we_i = 1'b1; cmd_wdata_i = mk_cmd(1'b1, 15, 1'b0);
        end
        if (cnt == dly) begin
          fetch_done_i = 1'b1; fetch_fail_i = fail; responded = 1;
        end
        cnt++;
      end
      if (sched_set_o) begin
        sched_n++; sched_seen = int'(sched_ch_o);
      end
      if (ind_valid_o) break;
      @(negedge clk);
    end
    fetch_done_i = 1'b0; fetch_fail_i = 1'b0; cmd_we_i = 1'b0;
    chk(ind_valid_o == 1'b1, {tag, " indication posted"}, 32'(ind_valid_o), 32'd1);
    chk(ind_rdata_o == exp_ind(mode, vc, e), {tag, " R8 indication word"},
        ind_rdata_o, exp_ind(mode, vc, e));
    chk(busy_o == 1'b0, "R2 busy low at indication", 32'(busy_o), 32'd0);
    chk(sched_n == (e ? 0 : 1), {tag, " activation count"}, 32'(sched_n), 32'(e ? 0 : 1));
    if (!e) chk(sched_seen == ch, "R3 activation channel", 32'(sched_seen), 32'(ch));
    chk(fetch_n == (want_fetch ? 1 : 0), {tag, " fetch request count"},
        32'(fetch_n), 32'(want_fetch ? 1 : 0));
    if (!e) begin
      m_used[ch] = 1'b1; m_mode[ch] = mode;
    end
  endtask

  initial begin : wdog
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] keep;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < NUM_CH; i++) begin m_used[i] = 0; m_mode[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy_o, ind_valid_o, fetch_req_o, sched_set_o} == 4'b0, "R10 control outputs",
        {28'b0, busy_o, ind_valid_o, fetch_req_o, sched_set_o}, 32'd0);
    chk(ind_rdata_o == 32'd0, "R10 indication word", ind_rdata_o, 32'd0);

    // R3 native success, junk bits ignored (R8)
    run_cmd(mk_cmd(1'b1, 3, 1'b1), 32'hA000_0010, 1'b0, 2, 1'b0);
    // R5 IP-over-ATM on default channel, binds it
    run_cmd(mk_cmd(1'b0, 0, 1'b0), 32'hA000_0020, 1'b0, 0, 1'b0);
    // R7 native request on the IP-over-ATM-bound entry
    run_cmd(mk_cmd(1'b1, IPOA_CH, 1'b0), 32'hA000_0030, 1'b0, 0, 1'b0);
    // R7 IP-over-ATM entry reused in its own mode is fine
    run_cmd(mk_cmd(1'b0, 0, 1'b0), 32'hA000_0034, 1'b0, 1, 1'b0);
    // R5 IP-over-ATM with a non-zero channel field
    run_cmd(mk_cmd(1'b0, 5, 1'b0), 32'hA000_0040, 1'b0, 0, 1'b0);
    // R4 out-of-range channel, and the top of the field
    run_cmd(mk_cmd(1'b1, NUM_CH, 1'b0), 32'hA000_0050, 1'b0, 0, 1'b0);
    run_cmd(mk_cmd(1'b1, 4095, 1'b0), 32'hA000_0054, 1'b0, 0, 1'b0);
    // R6 fetch failure, channel stays unbound
    run_cmd(mk_cmd(1'b1, 9, 1'b0), 32'hA000_0060, 1'b1, 3, 1'b0);
    // R2 write during a long fetch wait is ignored; channel 15 stays free
    run_cmd(mk_cmd(1'b1, 7, 1'b0), 32'hA000_0070, 1'b0, 6, 1'b1);
    run_cmd(mk_cmd(1'b0, 0, 1'b0), 32'hA000_0074, 1'b0, 0, 1'b0);

    // R1 wrong opcode ignored; R11 indication holds
    keep = ind_rdata_o;
    cmd_we_i = 1'b1; cmd_wdata_i = mk_cmd(1'b1, 2, 1'b0) ^ 32'h1000_0000;
    @(negedge clk);
    cmd_we_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy after bad opcode", 32'(busy_o), 32'd0);
    chk(ind_valid_o == 1'b1, "R1 R11 valid kept", 32'(ind_valid_o), 32'd1);
    chk(ind_rdata_o == keep, "R1 R11 word kept", ind_rdata_o, keep);

    // random phase
    for (int n = 0; n < 400; n++) begin
      bit md;
      int vcr;
      md = $urandom_range(0, 1) == 1;
      if (md) vcr = $urandom_range(0, 19);
      else vcr = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
      if ($urandom_range(0, 15) == 0) begin
        cmd_we_i = 1'b1; cmd_wdata_i = $urandom() & 32'h0FFF_FFFF;
        @(negedge clk);
        cmd_we_i = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 random bad opcode", 32'(busy_o), 32'd0);
      end
      run_cmd(mk_cmd(md, vcr, $urandom_range(0, 1) == 1), $urandom(),
              $urandom_range(0, 7) == 0, $urandom_range(0, 4), 1'b0);
    end

    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule